// File: doc/BRIEF.md
# Tagged Receive Demultiplexer

This block sits between a tile's router output port and the processor. It receives packets one word at a time over a valid/ready handshake and sorts each packet's payload into one of several receive queues.

A packet starts with a header word that gives the payload length. The second word is a tag that names the sending node, the stream and the message type. The block compares that tag against a tag register for each programmable queue. The payload words then go to the lowest-numbered enabled queue whose tag matches. If no queue matches, the payload goes to a catch-all queue, and the interrupt line stays high for as long as that queue holds data. The header and tag words are consumed and never stored.

The processor reads each queue through a head-of-queue data port, a not-empty flag and a one-cycle pop strobe. When the queue selected for the current packet is full, the block drops its ready output. It holds the stalled word until that queue has room.

Top module: `rx_tag_demux`

## Requirements
- R1: Bits [7:0] of the header word give the number of payload words N. Exactly the N words that follow the tag word are stored. The header and tag words are never stored.
- R2: Bits [15:0] of the tag word are compared with each queue's 16-bit tag register (slice q*16 of `cfg_tag`). The register fields are sender node in [15:8], stream in [7:4] and type in [3:0]. The payload goes to the queue whose enabled tag matches.
- R3: When several enabled queues hold the same matching tag, the queue with the lowest index receives the payload.
- R4: A packet whose tag matches no enabled queue sends its payload to the catch-all queue, which has index NUM_Q (4). `irq` is high exactly while the catch-all queue is non-empty.
- R5: A queue whose `cfg_en` bit is 0 never receives a payload, even when its tag matches.
- R6: While the queue selected for the current packet is full, `in_ready` is low during the payload phase. No word is lost or duplicated, and transfer resumes once the queue is popped.
- R7: Each queue returns its words in arrival order on its `q_data` slice. A pop removes the head word. A pop to an empty queue has no effect.
- R8: After reset, every queue is empty, `irq` is low, `in_ready` is high and the next word accepted is treated as a header.
- R9: A packet with N = 0 consumes only its header and tag. It stores nothing, does not raise `irq`, and leaves the block expecting a new header.
- R10: During the header and tag phases `in_ready` is high regardless of how full any queue is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming word valid |
| in_data | input | DATA_W | Incoming word (header, tag or payload) |
| in_ready | output | 1 | Block accepts the word this cycle |
| cfg_tag | input | NUM_Q*TAG_W | Tag register per programmable queue |
| cfg_en | input | NUM_Q | Enable per programmable queue |
| q_pop | input | NUM_Q+1 | Pop strobe per queue; bit NUM_Q is the catch-all |
| q_data | output | (NUM_Q+1)*DATA_W | Head word per queue |
| q_valid | output | NUM_Q+1 | Queue not empty |
| irq | output | 1 | Catch-all queue holds data |

## Verification
The assertions check several properties on every cycle. No queue is written while full. At most one queue is written per cycle. The tag match always selects exactly one destination. The payload phase never runs with a zero remaining count. A pop on an empty queue leaves it empty. The interrupt rises only after a catch-all write and falls only after a catch-all pop. Only the bench scenarios can show that payload words land in the right queue in the right order. The same holds for duplicate tags resolving to the lower queue, for disabled queues being skipped, for zero-length packets realigning the parser, and for a stalled packet completing without loss once the processor drains its queue.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_TAG  = 2'd1,
    PH_DATA = 2'd2
  } phase_t;
endpackage

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full      = (cnt == CW'(DEPTH));
  assign not_empty = (cnt != '0);
  assign do_push   = push & ~full;
  assign do_pop    = pop & not_empty;
  assign dout      = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R6: the parser must never present a word to a full queue
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);

  // R7: popping an empty queue leaves it empty
  p_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (!not_empty && pop && !push) |=> !not_empty);
endmodule

// File: rtl/rxd_tag_match.sv
module rxd_tag_match #(
  parameter int NUM_Q = 4,
  parameter int TAG_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TAG_W-1:0]       tag,
  input  logic [NUM_Q*TAG_W-1:0] cfg_tag,
  input  logic [NUM_Q-1:0]       cfg_en,
  output logic [NUM_Q:0]         grant
);
  logic [NUM_Q-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_Q; g++) begin : g_cmp
      assign hit[g] = cfg_en[g] && (cfg_tag[g*TAG_W +: TAG_W] == tag);
    end
  endgenerate

  // lowest index wins; catch-all when nothing hits
  always_comb begin
    grant = '0;
    for (int i = NUM_Q - 1; i >= 0; i--) begin
      if (hit[i]) grant = (NUM_Q+1)'(1) << i;
    end
    if (hit == '0) grant[NUM_Q] = 1'b1;
  end

  // R3: exactly one destination is chosen
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot(grant));
endmodule

// File: rtl/rxd_parser.sv
module rxd_parser
  import rxd_pkg::*;
#(
  parameter int NUM_Q  = 4,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [NUM_Q:0]    grant,
  input  logic [NUM_Q:0]    q_full,
  output logic [NUM_Q:0]    wr_vec,
  output logic [DATA_W-1:0] wr_data
);
  phase_t           ph;
  logic [LEN_W-1:0] remain;
  logic [NUM_Q:0]   sel;
  logic             accept;

  assign in_ready = (ph != PH_DATA) || ((sel & q_full) == '0);
  assign accept   = in_valid && in_ready;
  assign wr_vec   = (ph == PH_DATA && accept) ? sel : '0;
  assign wr_data  = in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_HDR;
      remain <= '0;
      sel    <= '0;
    end else if (accept) begin
      case (ph)
        PH_HDR: begin
          remain <= in_data[LEN_W-1:0];
          ph     <= PH_TAG;
        end
        PH_TAG: begin
          sel <= grant;
          ph  <= (remain == '0) ? PH_HDR : PH_DATA;
        end
        PH_DATA: begin
          remain <= remain - 1'b1;
          if (remain == LEN_W'(1)) ph <= PH_HDR;
        end
        default: ph <= PH_HDR;
      endcase
    end
  end

  // R1: the payload phase always has words left to take
  p_data_count_r1: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DATA) |-> (remain != '0));

  // R2: a payload word goes to at most one queue
  p_single_write_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_vec));

  // R8: the first phase after reset is the header phase
  p_reset_phase_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ph == PH_HDR));
endmodule

// File: rtl/rx_tag_demux.sv
module rx_tag_demux #(
  parameter int DATA_W = 32,
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 16,
  parameter int LEN_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [DATA_W-1:0]           in_data,
  output logic                        in_ready,
  input  logic [NUM_Q*TAG_W-1:0]      cfg_tag,
  input  logic [NUM_Q-1:0]            cfg_en,
  input  logic [NUM_Q:0]              q_pop,
  output logic [(NUM_Q+1)*DATA_W-1:0] q_data,
  output logic [NUM_Q:0]              q_valid,
  output logic                        irq
);
  localparam int NQ = NUM_Q + 1;
  localparam int CA = NUM_Q;

  logic [NUM_Q:0]    grant;
  logic [NUM_Q:0]    q_full;
  logic [NUM_Q:0]    wr_vec;
  logic [DATA_W-1:0] wr_data;

  rxd_tag_match #(.NUM_Q(NUM_Q), .TAG_W(TAG_W)) u_match (
    .clk     (clk),
    .rst     (rst),
    .tag     (in_data[TAG_W-1:0]),
    .cfg_tag (cfg_tag),
    .cfg_en  (cfg_en),
    .grant   (grant)
  );

  rxd_parser #(.NUM_Q(NUM_Q), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_parse (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .grant    (grant),
    .q_full   (q_full),
    .wr_vec   (wr_vec),
    .wr_data  (wr_data)
  );

  genvar g;
  generate
    for (g = 0; g < NQ; g++) begin : g_q
      rxd_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_vec[g]),
        .din       (wr_data),
        .pop       (q_pop[g]),
        .dout      (q_data[g*DATA_W +: DATA_W]),
        .not_empty (q_valid[g]),
        .full      (q_full[g])
      );
    end
  endgenerate

  assign irq = q_valid[CA];

  // R4: the interrupt only rises after a payload word went to the catch-all
  p_irq_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(wr_vec[CA]));

  // R4: the interrupt only falls after the catch-all was popped
  p_irq_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(q_pop[CA]));
endmodule

// File: tb/sim_rx_tag_demux.sv
`timescale 1ns/1ps
module sim_rx_tag_demux;
  localparam int NQ = 5;
  localparam int CA = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [31:0]   in_data = '0;
  logic          in_ready;
  logic [63:0]   cfg_tag;
  logic [3:0]    cfg_en;
  logic [4:0]    q_pop = '0;
  logic [159:0]  q_data;
  logic [4:0]    q_valid;
  logic          irq;

  int nchecks = 0;
  int nfail   = 0;

  always #2 clk = ~clk;

  rx_tag_demux u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cfg_tag(cfg_tag), .cfg_en(cfg_en),
    .q_pop(q_pop), .q_data(q_data), .q_valid(q_valid), .irq(irq)
  );

  // entry: {tag[15:0], length[7:0], expected queue[7:0]}
  localparam logic [31:0] VEC [0:5] = '{
    {16'h1A21, 8'd3,  8'd0},   // R3 duplicate tag in q0 and q2
    {16'h2B32, 8'd2,  8'd1},   // R2 plain match
    {16'h3C43, 8'd2,  8'd4},   // R5 tag of disabled q3
    {16'h7777, 8'd1,  8'd4},   // R4 unknown tag
    {16'h2B32, 8'd16, 8'd1},   // R1 typical sixteen-word payload
    {16'h1A21, 8'd1,  8'd0}    // R7 single word
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(logic [31:0] d);
    logic rdy;
    in_valid = 1'b1;
    in_data  = d;
    do begin
      rdy = in_ready;
      @(posedge clk);
      @(negedge clk);
    end while (!rdy);
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(logic [15:0] tag, int len, logic [31:0] base);
    send_word({24'h0, 8'(len)});
    send_word({16'h0, tag});
    for (int i = 0; i < len; i++) send_word(base + 32'(i));
  endtask

  task automatic pop_word(int q, logic [31:0] exp, string req);
    chk(req, {31'h0, q_valid[q]}, 32'h1);
    chk(req, q_data[q*32 +: 32], exp);
    q_pop[q] = 1'b1;
    @(negedge clk);
    q_pop[q] = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    cfg_tag = {16'h3C43, 16'h1A21, 16'h2B32, 16'h1A21};
    cfg_en  = 4'b0111;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8: reset state
    chk("R8 in_ready", {31'h0, in_ready}, 32'h1);
    chk("R8 q_valid", {27'h0, q_valid}, 32'h0);
    chk("R8 irq", {31'h0, irq}, 32'h0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic [31:0] base;
      int len;
      int q;
      base = 32'hA000_0000 | (32'(v) << 16);
      len  = int'(VEC[v][15:8]);
      q    = int'(VEC[v][7:0]);
      send_pkt(VEC[v][31:16], len, base);
      @(negedge clk);
      chk($sformatf("R4 irq vec%0d", v), {31'h0, irq}, {31'h0, q == CA});
      for (int k = 0; k < NQ; k++)
        if (k != q) chk($sformatf("R2 other queue %0d vec%0d", k, v),
                        {31'h0, q_valid[k]}, 32'h0);
      for (int i = 0; i < len; i++)
        pop_word(q, base + 32'(i), $sformatf("R1 R7 vec%0d word%0d", v, i));
      chk($sformatf("R1 drained vec%0d", v), {27'h0, q_valid}, 32'h0);
      chk($sformatf("R4 irq clear vec%0d", v), {31'h0, irq}, 32'h0);
    end

    // R9: zero-length miss, then a normal packet
    send_pkt(16'h5555, 0, 32'h0);
    @(negedge clk);
    chk("R9 no irq", {31'h0, irq}, 32'h0);
    chk("R9 nothing stored", {27'h0, q_valid}, 32'h0);
    send_pkt(16'h2B32, 1, 32'hB000_0001);
    pop_word(1, 32'hB000_0001, "R9 realigned");

    // R7: pop on empty has no effect
    q_pop[1] = 1'b1;
    @(negedge clk);
    q_pop[1] = 1'b0;
    send_pkt(16'h2B32, 1, 32'hB000_0002);
    pop_word(1, 32'hB000_0002, "R7 pop empty");
    chk("R7 single word", {31'h0, q_valid[1]}, 32'h0);

    // R10: q0 full, packet to q1 still flows
    send_pkt(16'h1A21, 16, 32'hC000_0000);
    chk("R10 ready with q0 full", {31'h0, in_ready}, 32'h1);
    send_pkt(16'h2B32, 1, 32'hC100_0000);
    pop_word(1, 32'hC100_0000, "R10 q1 word");
    for (int i = 0; i < 16; i++) pop_word(0, 32'hC000_0000 + 32'(i), "R7 order q0");

    // R6: backpressure with a twenty-word payload into q0
    fork
      send_pkt(16'h1A21, 20, 32'hD000_0000);
      begin
        repeat (30) @(negedge clk);
        chk("R6 stalled", {31'h0, in_ready}, 32'h0);
        for (int i = 0; i < 20; i++) begin
          while (!q_valid[0]) @(negedge clk);
          pop_word(0, 32'hD000_0000 + 32'(i), "R6 no loss");
        end
      end
    join
    @(negedge clk);
    chk("R6 drained", {31'h0, q_valid[0]}, 32'h0);
    chk("R6 ready again", {31'h0, in_ready}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule